// File: doc/BRIEF.md
# Shaped-Keying Amplitude Envelope Controller

This block sits between a signed sample source and a DAC and scales every sample by an unsigned 12-bit amplitude factor. It can take that factor from a directly written amplitude value. It can also run a linear envelope that a keying level drives: while the key is high the factor climbs one step at a time to full scale and holds there. When the key goes low the factor falls one step at a time to zero and holds there. A programmable rate value sets how many clocks pass between steps. A key reversal in the middle of a ramp turns the ramp around from the present value, so the output never jumps.

Samples enter and leave on valid/ready streams with a single output register. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure from the DAC side passes straight to the source. A held output word stays unchanged until the sink takes it. When the multiplier is switched out, its operands are forced to zero and samples pass through unscaled. Two status flags report full scale and zero scale, and they are registered together with the factor.

Top module: `shaped_key_env`

## Requirements
- R1: A synchronous reset makes the amplitude factor 0 and clears the step counter. On the next cycle at_zero is 1, at_full is 0 and m_valid is 0.
- R2: s_ready equals (not m_valid) or m_ready. A sample accepted on a clock edge (s_valid and s_ready) appears on m_data with m_valid high after that edge. While m_valid is high and m_ready is low, m_valid and m_data hold.
- R3: With mul_en high, m_data equals floor((x*g + 2048) / 4096), where x is the accepted signed 16-bit sample and g is the amplitude factor in effect on the accepting edge, before that edge updates it.
- R4: With mul_en low, m_data equals the accepted sample unchanged.
- R5: With auto_en low, the amplitude factor loads manual_amp on every clock, and the step counter is held at 0.
- R6: With auto_en and key_in high and the factor below 4095, the step counter increments each clock. On the clock where the counter is greater than or equal to ramp_rate, the factor rises by 1 and the counter returns to 0. One step therefore takes ramp_rate+1 clocks.
- R7: With auto_en and key_in high and the factor at 4095, the factor stays at 4095.
- R8: With auto_en high and key_in low, the factor falls by 1 per step with the same counting rule as R6 until it reaches 0, and then stays at 0.
- R9: A change of key_in during a ramp reverses the direction from the present factor on the next step, and the step counter keeps its count.
- R10: at_full is 1 exactly when the factor is 4095, and at_zero is 1 exactly when the factor is 0. Both flags change on the same clock as the factor.
- R11: In auto mode, while the factor equals its target (4095 with key_in high, 0 with key_in low), the step counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept an input sample |
| s_data | input | 16 | Signed input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Sink accepts the output sample |
| m_data | output | 16 | Signed scaled output sample |
| mul_en | input | 1 | 1: multiply by the factor; 0: bypass, samples pass unscaled |
| auto_en | input | 1 | 1: the keying envelope drives the factor; 0: manual_amp drives it |
| key_in | input | 1 | Synchronous keying level |
| ramp_rate | input | 8 | Step interval minus one, in clocks |
| manual_amp | input | 12 | Amplitude factor used when auto_en is 0 |
| at_full | output | 1 | Factor is at full scale (4095) |
| at_zero | output | 1 | Factor is at zero |

## Verification
The critical overlap is a sample being accepted on the same edge where the envelope takes a step. The sample must be scaled by the value from before the step. A stall of the output register on that edge must hold the earlier product rather than pick up the new gain. The bench runs long ramps with random input validity and random sink readiness, so step edges fall on accept edges and on stall edges many times over. It also reverses the key in mid-ramp and lowers the rate below the running count. A behavioural model compares every output word and both flags on every clock.

// File: rtl/sk_env_pkg.sv
package sk_env_pkg;

  typedef enum logic [1:0] {
    GAIN_MANUAL = 2'd0,
    GAIN_HOLD   = 2'd1,
    GAIN_RISE   = 2'd2,
    GAIN_FALL   = 2'd3
  } gain_mode_e;

endpackage

// File: rtl/sk_gain_ramp.sv
module sk_gain_ramp
  import sk_env_pkg::*;
#(
  parameter int AW = 12,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_en,
  input  logic          key_in,
  input  logic [RW-1:0] ramp_rate,
  input  logic [AW-1:0] manual_amp,
  output logic [AW-1:0] gain,
  output logic          at_full,
  output logic          at_zero
);

  localparam logic [AW-1:0] FULL = {AW{1'b1}};
  localparam logic [AW-1:0] NONE = '0;

  logic [AW-1:0] gain_q, gain_d, target;
  logic [RW-1:0] cnt_q, cnt_d;
  logic          full_q, zero_q, step;
  gain_mode_e    mode;

  always_comb begin
    target = key_in ? FULL : NONE;
    step   = (cnt_q >= ramp_rate);
    if (!auto_en)              mode = GAIN_MANUAL;
    else if (gain_q == target) mode = GAIN_HOLD;
    else if (key_in)           mode = GAIN_RISE;
    else                       mode = GAIN_FALL;
  end

  always_comb begin
    gain_d = gain_q;
    cnt_d  = cnt_q;
    unique case (mode)
      GAIN_MANUAL: begin
        gain_d = manual_amp;
        cnt_d  = '0;
      end
      GAIN_HOLD: cnt_d = '0;
      GAIN_RISE: begin
        if (step) begin
          gain_d = gain_q + 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      GAIN_FALL: begin
        if (step) begin
          gain_d = gain_q - 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      zero_q <= 1'b1;
    end else begin
      gain_q <= gain_d;
      cnt_q  <= cnt_d;
      full_q <= (gain_d == FULL);
      zero_q <= (gain_d == NONE);
    end
  end

  assign gain    = gain_q;
  assign at_full = full_q;
  assign at_zero = zero_q;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (gain_q == NONE && cnt_q == '0 && zero_q && !full_q));

  a_r5_manual_load: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(!auto_en) |-> (gain_q == $past(manual_amp) && cnt_q == '0));

  a_r6_rise_unit: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(auto_en && key_in) && $past(gain_q) != FULL)
      |-> (AW'(gain_q - $past(gain_q)) <= AW'(1)));

  a_r7_hold_full: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(auto_en && key_in) && $past(gain_q) == FULL) |-> gain_q == FULL);

  a_r8_fall_unit: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(auto_en && !key_in) && $past(gain_q) != NONE)
      |-> (AW'($past(gain_q) - gain_q) <= AW'(1)));

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(auto_en && !key_in) && $past(gain_q) == NONE) |-> gain_q == NONE);

  a_r10_flags_track: assert property (@(posedge clk) disable iff (rst)
    (full_q == (gain_q == FULL)) && (zero_q == (gain_q == NONE)));

  a_r11_idle_count: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(auto_en) && $past(gain_q == target)) |-> cnt_q == '0);

endmodule

// File: rtl/sk_scaler.sv
module sk_scaler #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic        [AW-1:0] g,
  output logic signed [DW-1:0] y
);

  localparam int PW = DW + AW + 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (AW - 1);

  logic signed [DW-1:0] xi;
  logic signed [AW:0]   gi;
  logic signed [PW-1:0] prod, sum;

  always_comb begin
    xi   = en ? x : '0;
    gi   = en ? $signed({1'b0, g}) : '0;
    prod = PW'(xi) * PW'(gi);
    sum  = prod + HALF;
  end

  assign y = en ? DW'(sum >>> AW) : x;

endmodule

// File: rtl/sk_out_stage.sv
module sk_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] d_in,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);

  logic          v_q;
  logic [DW-1:0] d_q;

  assign s_ready = !v_q || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (s_ready) begin
      v_q <= s_valid;
      if (s_valid) d_q <= d_in;
    end
  end

  assign m_valid = v_q;
  assign m_data  = d_q;

  a_r1_empty_after_reset: assert property (@(posedge clk) rst |=> !m_valid);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r2_accept_valid: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> m_valid);

endmodule

// File: rtl/shaped_key_env.sv
module shaped_key_env #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  input  logic          mul_en,
  input  logic          auto_en,
  input  logic          key_in,
  input  logic [RW-1:0] ramp_rate,
  input  logic [AW-1:0] manual_amp,
  output logic          at_full,
  output logic          at_zero
);

  logic [AW-1:0] gain;
  logic [DW-1:0] scaled;

  sk_gain_ramp #(.AW(AW), .RW(RW)) u_ramp (
    .clk        (clk),
    .rst        (rst),
    .auto_en    (auto_en),
    .key_in     (key_in),
    .ramp_rate  (ramp_rate),
    .manual_amp (manual_amp),
    .gain       (gain),
    .at_full    (at_full),
    .at_zero    (at_zero)
  );

  sk_scaler #(.DW(DW), .AW(AW)) u_scale (
    .en (mul_en),
    .x  (s_data),
    .g  (gain),
    .y  (scaled)
  );

  sk_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .d_in    (scaled),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data)
  );

  a_r4_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (!mul_en && s_valid && s_ready) |=> m_data == $past(s_data));

  a_r3_zero_gain: assert property (@(posedge clk) disable iff (rst)
    (mul_en && at_zero && s_valid && s_ready) |=> m_data == '0);

endmodule

// File: tb/tb_shaped_key_env.sv
module tb_shaped_key_env;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0, m_ready = 1'b0;
  logic [15:0] s_data = '0;
  logic        mul_en = 1'b1, auto_en = 1'b0, key_in = 1'b0;
  logic [7:0]  ramp_rate = '0;
  logic [11:0] manual_amp = '0;
  logic        s_ready, m_valid, at_full, at_zero;
  logic [15:0] m_data;

  always #5 clk = ~clk;

  shaped_key_env dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .mul_en(mul_en),
    .auto_en(auto_en), .key_in(key_in), .ramp_rate(ramp_rate),
    .manual_amp(manual_amp), .at_full(at_full), .at_zero(at_zero)
  );

  int    n_checks = 0, n_fails = 0;
  string phase = "R1 reset";
  bit    finished = 1'b0;
  int    vld_pct = 70, rdy_pct = 70;

  // reference model state
  int    mg = 0, mc = 0;
  bit    mv = 1'b0, mfull = 1'b0, mzero = 1'b1;
  int    md = 0;

  function automatic int scale_ref(logic [15:0] x, int g, bit en);
    int p;
    if (!en) return int'($signed(x));
    p = int'($signed(x)) * g + 2048;
    return p >>> 12;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mv = 1'b0; md = 0; mg = 0; mc = 0; mfull = 1'b0; mzero = 1'b1;
    end else begin
      if (!mv || m_ready) begin
        mv = s_valid;
        if (s_valid) md = scale_ref(s_data, mg, mul_en);
      end
      if (!auto_en) begin
        mg = int'(manual_amp); mc = 0;
      end else begin
        int tgt;
        tgt = key_in ? 4095 : 0;
        if (mg == tgt) mc = 0;
        else if (mc >= int'(ramp_rate)) begin
          mg = key_in ? mg + 1 : mg - 1;
          mc = 0;
        end else mc = mc + 1;
      end
      mfull = (mg == 4095);
      mzero = (mg == 0);
    end
  end

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  // per-cycle comparison, 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (!rst && !finished) begin
      check("R2 m_valid", int'(m_valid), int'(mv));
      check("R2 s_ready", int'(s_ready), int'(!mv || m_ready));
      check("R10 at_full", int'(at_full), int'(mfull));
      check("R10 at_zero", int'(at_zero), int'(mzero));
      if (mv) begin
        if (mul_en) check("R3 m_data", int'($signed(m_data)), md);
        else        check("R4 m_data", int'($signed(m_data)), md);
      end
    end
  end

  // stream stimulus
  always @(negedge clk) begin
    if (!finished) begin
      s_valid <= ($urandom % 100) < vld_pct;
      m_ready <= ($urandom % 100) < rdy_pct;
      s_data  <= 16'($urandom);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    phase = "R1 reset";
    check("R1 at_zero", int'(at_zero), 1);
    check("R1 at_full", int'(at_full), 0);
    check("R1 m_valid", int'(m_valid), 0);

    phase = "R5 manual gain";
    mul_en = 1'b1; auto_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      manual_amp = 12'($urandom);
      run(12);
    end
    manual_amp = 12'd4095; run(10);
    manual_amp = 12'd0;    run(10);

    phase = "R4 bypass";
    mul_en = 1'b0; manual_amp = 12'd1000; run(40);
    mul_en = 1'b1;

    phase = "R6 ramp up rate 0";
    manual_amp = 12'd0; run(2);
    auto_en = 1'b1; key_in = 1'b1; ramp_rate = 8'd0;
    run(4200);
    phase = "R7 hold full";
    run(100);
    check("R7 at_full", int'(at_full), 1);

    phase = "R8 ramp down rate 3";
    key_in = 1'b0; ramp_rate = 8'd3; rdy_pct = 40;
    run(16500);
    check("R8 at_zero", int'(at_zero), 1);
    phase = "R11 idle at zero";
    run(50);

    phase = "R9 reversal";
    rdy_pct = 70; ramp_rate = 8'd2;
    key_in = 1'b1; run(301);
    key_in = 1'b0; run(151);
    key_in = 1'b1; run(77);
    key_in = 1'b0; run(5);
    key_in = 1'b1; run(4);

    phase = "R6 rate change below count";
    ramp_rate = 8'd200; run(150);
    ramp_rate = 8'd5;   run(300);

    phase = "R5 manual to auto no jump";
    auto_en = 1'b0; manual_amp = 12'd4000; run(10);
    auto_en = 1'b1; key_in = 1'b1; ramp_rate = 8'd1; run(300);
    check("R7 at_full after climb", int'(at_full), 1);

    phase = "R4 bypass during ramp";
    mul_en = 1'b0; key_in = 1'b0; run(200);
    mul_en = 1'b1; run(100);

    phase = "R1 mid-run reset";
    rst = 1'b1; run(2); rst = 1'b0;
    #2;
    check("R1 at_zero after reset", int'(at_zero), 1);
    run(20);

    finish_up();
  end

endmodule